// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address by reading translation entries from memory. Software first loads the frame number of the top-level directory into a base register. After that, each translation request starts a walk. The walker fetches the directory entry. If that entry marks a large 4 MB page, the walk ends there. Otherwise the walker fetches a second-level table entry and builds a 4 KB page address.

Requests arrive on a valid/ready port, and only one is handled at a time. Entry reads go out as 32-bit word reads on a request/response port, and the response may come back after any number of cycles. Each result comes back on a valid/ready result port. It carries either a physical address or a fault code, together with the linear address that was translated.

Top module: `pt_walker`

## Requirements
- R1: After reset, `req_ready` is 1, `res_valid` is 0 and `mem_req_valid` is 0. No base is loaded yet.
- R2: While no base has been written since reset, an accepted request makes no memory read. It returns `res_fault`=1 with `res_paddr`=0.
- R3: The first read goes to byte address {base_frm, 12'h000} + 4 × laddr[31:22]. Every read address is word aligned.
- R4: If the directory entry has bit 0 (present) set and bit 7 (size) clear, a second read goes to {entry[31:12], 12'h000} + 4 × laddr[21:12]. When the second entry has bit 0 set, the result is `res_paddr` = {entry2[31:12], laddr[11:0]} with `res_fault`=0.
- R5: If the directory entry has bit 0 and bit 7 both set, no second read is made. The result is `res_paddr` = {entry[31:22], laddr[21:0]} with `res_fault`=0.
- R6: If the directory entry has bit 0 clear, whatever bit 7 holds, the walk ends after one read. It returns `res_fault`=2 with `res_paddr`=0.
- R7: If the second-level entry has bit 0 clear, the walk ends after two reads. It returns `res_fault`=3 with `res_paddr`=0.
- R8: `req_ready` stays 0 from the accepted request until the result handshake. While `res_ready` is low, `res_valid` and the result fields hold. `res_laddr` echoes the request address.
- R9: `mem_req_valid` and `mem_req_addr` hold until `mem_req_ready` is seen. The walker waits any number of cycles for `mem_rsp_valid`.
- R10: A base write made during a walk does not change that walk's reads. It applies from the next request on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_wr_en | input | 1 | Load the directory base |
| base_wr_frm | input | 20 | Directory frame number (address bits 31:12) |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker can take a request |
| req_laddr | input | 32 | Linear address to translate |
| mem_req_valid | output | 1 | Entry read request valid |
| mem_req_ready | input | 1 | Memory took the read |
| mem_req_addr | output | 32 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Entry read back |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Result consumer ready |
| res_paddr | output | 32 | Physical address, 0 on fault |
| res_laddr | output | 32 | Linear address of this result |
| res_fault | output | 2 | 0 ok, 1 no base, 2 directory absent, 3 table absent |

## Verification
The walker is tried with several address patterns:
- A request made before any base load, to check it is refused with no memory traffic.
- A normal two-read 4 KB walk.
- A large-page entry, to confirm the second read is skipped and offset bits 21:12 pass through.
- An absent directory entry, including one whose size bit is set, so the level of the fault can be told apart.
- An absent table entry.
- The all-ones address, which checks the top index and offset bits.

A base rewritten in the middle of a walk, followed by a repeat of the same address, shows which base each walk used. Memory grant and response delays change from read to read, and the consumer applies back-pressure, so handshake holding is exercised throughout.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
    localparam int XW        = 32;
    localparam int OFF_W     = 12;
    localparam int IDX_W     = 10;
    localparam int ENT_LG    = 2;
    localparam int FRM_W     = XW - OFF_W;
    localparam int BIG_OFF_W = IDX_W + OFF_W;
    localparam int BIG_FRM_W = XW - BIG_OFF_W;
    localparam int PRESENT_BIT = 0;
    localparam int PSIZE_BIT   = 7;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'd0,
        FLT_NOBASE = 2'd1,
        FLT_DIR    = 2'd2,
        FLT_TBL    = 2'd3
    } fault_e;

    typedef enum logic [2:0] {
        W_IDLE, W_DIR_REQ, W_DIR_WAIT, W_TBL_REQ, W_TBL_WAIT, W_DONE
    } walk_e;
endpackage

// File: rtl/xlat_base_reg.sv
module xlat_base_reg
    import xlat_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [FRM_W-1:0] wr_frm,
    output logic [FRM_W-1:0] base_frm,
    output logic             loaded
);
    typedef struct packed {
        logic [FRM_W-1:0] frm;
        logic             ld;
    } base_t;

    base_t q, d;

    always_comb begin
        d = q;
        if (wr_en) begin
            d.frm = wr_frm;
            d.ld  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign base_frm = q.frm;
    assign loaded   = q.ld;

    AST_LOADED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        loaded |=> loaded); // R2
endmodule

// File: rtl/xlat_entry_addr.sv
module xlat_entry_addr
    import xlat_pkg::*;
(
    input  logic             sel_tbl,
    input  logic [FRM_W-1:0] dir_frm,
    input  logic [FRM_W-1:0] tbl_frm,
    input  logic [IDX_W-1:0] dir_idx,
    input  logic [IDX_W-1:0] tbl_idx,
    output logic [XW-1:0]    addr
);
    logic [FRM_W-1:0] frm;
    logic [IDX_W-1:0] idx;

    always_comb begin
        frm  = sel_tbl ? tbl_frm : dir_frm;
        idx  = sel_tbl ? tbl_idx : dir_idx;
        addr = {frm, {OFF_W{1'b0}}} + (XW'(idx) << ENT_LG);
    end
endmodule

// File: rtl/xlat_walk_fsm.sv
module xlat_walk_fsm
    import xlat_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [XW-1:0]    req_laddr,
    input  logic [FRM_W-1:0] base_frm,
    input  logic             base_loaded,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic             rd_tbl_lvl,
    output logic [FRM_W-1:0] dir_frm,
    output logic [FRM_W-1:0] tbl_frm,
    output logic [XW-1:0]    cur_laddr,
    input  logic             mem_rsp_valid,
    input  logic [XW-1:0]    mem_rsp_data,
    output logic             res_valid,
    input  logic             res_ready,
    output logic [XW-1:0]    res_paddr,
    output logic [1:0]       res_fault
);
    typedef struct packed {
        walk_e            st;
        logic [XW-1:0]    la;
        logic [FRM_W-1:0] dfrm;
        logic [FRM_W-1:0] tfrm;
        logic [XW-1:0]    pa;
        fault_e           flt;
    } wstate_t;

    wstate_t q, d;

    logic ent_present, ent_big;
    logic unused_ent_bits;

    assign ent_present     = mem_rsp_data[PRESENT_BIT];
    assign ent_big         = mem_rsp_data[PSIZE_BIT];
    assign unused_ent_bits = ^{mem_rsp_data[OFF_W-1:PSIZE_BIT+1],
                               mem_rsp_data[PSIZE_BIT-1:PRESENT_BIT+1]};

    always_comb begin
        d = q;
        unique case (q.st)
            W_IDLE: begin
                if (req_valid) begin
                    d.la   = req_laddr;
                    d.dfrm = base_frm;
                    d.pa   = '0;
                    if (!base_loaded) begin
                        d.flt = FLT_NOBASE;
                        d.st  = W_DONE;
                    end else begin
                        d.flt = FLT_NONE;
                        d.st  = W_DIR_REQ;
                    end
                end
            end
            W_DIR_REQ: begin
                if (mem_req_ready) d.st = W_DIR_WAIT;
            end
            W_DIR_WAIT: begin
                if (mem_rsp_valid) begin
                    if (!ent_present) begin
                        d.flt = FLT_DIR;
                        d.st  = W_DONE;
                    end else if (ent_big) begin
                        d.pa = {mem_rsp_data[XW-1 -: BIG_FRM_W], q.la[BIG_OFF_W-1:0]};
                        d.st = W_DONE;
                    end else begin
                        d.tfrm = mem_rsp_data[XW-1 -: FRM_W];
                        d.st   = W_TBL_REQ;
                    end
                end
            end
            W_TBL_REQ: begin
                if (mem_req_ready) d.st = W_TBL_WAIT;
            end
            W_TBL_WAIT: begin
                if (mem_rsp_valid) begin
                    if (!ent_present) begin
                        d.flt = FLT_TBL;
                    end else begin
                        d.pa = {mem_rsp_data[XW-1 -: FRM_W], q.la[OFF_W-1:0]};
                    end
                    d.st = W_DONE;
                end
            end
            W_DONE: begin
                if (res_ready) d.st = W_IDLE;
            end
            default: d.st = W_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign req_ready     = (q.st == W_IDLE);
    assign mem_req_valid = (q.st == W_DIR_REQ) || (q.st == W_TBL_REQ);
    assign rd_tbl_lvl    = (q.st == W_TBL_REQ);
    assign dir_frm       = q.dfrm;
    assign tbl_frm       = q.tfrm;
    assign cur_laddr     = q.la;
    assign res_valid     = (q.st == W_DONE);
    assign res_paddr     = q.pa;
    assign res_fault     = q.flt;

    AST_READY_WHILE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> !req_ready); // R8

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_ready) |=>
            (res_valid && $stable(res_paddr) && $stable(res_fault) && $stable(cur_laddr))); // R8

    AST_NOBASE_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !base_loaded) |=>
            (res_valid && res_fault == FLT_NOBASE && res_paddr == '0)); // R2

    AST_BIG_SKIPS_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.st == W_DIR_WAIT) && mem_rsp_valid && ent_present && ent_big) |=>
            (res_valid && res_fault == FLT_NONE)); // R5

    AST_DIR_ABSENT: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.st == W_DIR_WAIT) && mem_rsp_valid && !ent_present) |=>
            (res_valid && res_fault == FLT_DIR)); // R6
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import xlat_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             base_wr_en,
    input  logic [FRM_W-1:0] base_wr_frm,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [XW-1:0]    req_laddr,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic [XW-1:0]    mem_req_addr,
    input  logic             mem_rsp_valid,
    input  logic [XW-1:0]    mem_rsp_data,
    output logic             res_valid,
    input  logic             res_ready,
    output logic [XW-1:0]    res_paddr,
    output logic [XW-1:0]    res_laddr,
    output logic [1:0]       res_fault
);
    logic [FRM_W-1:0] base_frm, dir_frm, tbl_frm;
    logic             base_loaded, rd_tbl_lvl;
    logic [XW-1:0]    cur_laddr;

    xlat_base_reg u_base (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (base_wr_en),
        .wr_frm   (base_wr_frm),
        .base_frm (base_frm),
        .loaded   (base_loaded)
    );

    xlat_walk_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_laddr     (req_laddr),
        .base_frm      (base_frm),
        .base_loaded   (base_loaded),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .rd_tbl_lvl    (rd_tbl_lvl),
        .dir_frm       (dir_frm),
        .tbl_frm       (tbl_frm),
        .cur_laddr     (cur_laddr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .res_valid     (res_valid),
        .res_ready     (res_ready),
        .res_paddr     (res_paddr),
        .res_fault     (res_fault)
    );

    xlat_entry_addr u_addr (
        .sel_tbl (rd_tbl_lvl),
        .dir_frm (dir_frm),
        .tbl_frm (tbl_frm),
        .dir_idx (cur_laddr[BIG_OFF_W +: IDX_W]),
        .tbl_idx (cur_laddr[OFF_W +: IDX_W]),
        .addr    (mem_req_addr)
    );

    assign res_laddr = cur_laddr;

    AST_READ_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_addr[ENT_LG-1:0] == '0)); // R3

    AST_MEM_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R9

    AST_BASE_FROZEN_IN_WALK: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && $past(!req_ready)) |-> $stable(dir_frm)); // R10
endmodule

// File: tb/pt_walker_tb.sv
module pt_walker_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        base_wr_en;
    logic [19:0] base_wr_frm;
    logic        req_valid;
    logic        req_ready;
    logic [31:0] req_laddr;
    logic        mem_req_valid;
    logic        mem_req_ready;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_data;
    logic        res_valid;
    logic        res_ready;
    logic [31:0] res_paddr;
    logic [31:0] res_laddr;
    logic [1:0]  res_fault;

    always #5 clk = ~clk;

    pt_walker u_dut (
        .clk(clk), .rst_n(rst_n),
        .base_wr_en(base_wr_en), .base_wr_frm(base_wr_frm),
        .req_valid(req_valid), .req_ready(req_ready), .req_laddr(req_laddr),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .res_valid(res_valid), .res_ready(res_ready), .res_paddr(res_paddr),
        .res_laddr(res_laddr), .res_fault(res_fault)
    );

    typedef struct {
        logic [31:0] la;
        logic [1:0]  code;
        logic [31:0] pa;
        int          nrd;
        logic [31:0] a0;
        logic [31:0] a1;
        string       tag;
    } exp_t;

    exp_t        exp_q[$];
    logic [31:0] rd_log[$];
    logic [31:0] mem [logic [31:0]];
    int          total = 0;
    int          bad = 0;
    int          rd_n = 0;
    int          cyc = 0;
    bit          busy = 1'b0;
    bit          ready_seen = 1'b0;

    function automatic logic [31:0] mrd(logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    task automatic chk(bit ok, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", what, act, exp);
        end
    endtask

    task automatic set_base(logic [19:0] v);
        @(negedge clk);
        base_wr_en  = 1'b1;
        base_wr_frm = v;
        @(negedge clk);
        base_wr_en  = 1'b0;
    endtask

    // driver: queue the expectation, then offer the request
    task automatic xlate(logic [31:0] la, logic [1:0] code, logic [31:0] pa,
                         int nrd, logic [31:0] a0, logic [31:0] a1, string tag);
        exp_t e;
        e.la = la; e.code = code; e.pa = pa; e.nrd = nrd; e.a0 = a0; e.a1 = a1; e.tag = tag;
        @(negedge clk);
        exp_q.push_back(e);
        req_laddr = la;
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        busy = 1'b1;
        wait (!busy);
    endtask

    // memory model with varying grant and response delays (R9)
    initial begin
        logic [31:0] a;
        mem_req_ready = 1'b0;
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = '0;
        forever begin
            @(negedge clk);
            if (mem_req_valid) begin
                repeat (rd_n % 3) @(negedge clk);
                a = mem_req_addr;
                rd_log.push_back(a);
                mem_req_ready = 1'b1;
                @(negedge clk);
                mem_req_ready = 1'b0;
                repeat ((rd_n + 1) % 4) @(negedge clk);
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = mrd(a);
                @(negedge clk);
                mem_rsp_valid = 1'b0;
                rd_n++;
            end
        end
    end

    // monitor: back-pressure, hold checks and scoreboard compare
    initial begin
        logic [31:0] held_pa;
        logic [1:0]  held_flt;
        bit          held = 1'b0;
        exp_t e;
        res_ready = 1'b0;
        forever begin
            @(negedge clk);
            cyc++;
            res_ready = (cyc % 3) != 0;
            #1;
            if (busy && req_ready) ready_seen = 1'b1;
            if (res_valid && !held) begin
                held = 1'b1; held_pa = res_paddr; held_flt = res_fault;
            end
            if (res_valid && res_ready && exp_q.size() > 0) begin
                e = exp_q.pop_front();
                chk(res_fault == e.code, {e.tag, " fault code"}, 32'(res_fault), 32'(e.code));
                chk(res_paddr == e.pa, {e.tag, " paddr"}, res_paddr, e.pa);
                chk(res_laddr == e.la, {e.tag, " R8 laddr echo"}, res_laddr, e.la);
                chk(res_paddr == held_pa && res_fault == held_flt, {e.tag, " R8 result held"},
                    res_paddr, held_pa);
                chk(!ready_seen, {e.tag, " R8 req_ready low during walk"},
                    32'(ready_seen), 32'd0);
                chk(rd_log.size() == e.nrd, {e.tag, " R9 read count"},
                    32'(rd_log.size()), 32'(e.nrd));
                if (e.nrd > 0 && rd_log.size() > 0)
                    chk(rd_log[0] == e.a0, {e.tag, " R3 first read addr"}, rd_log[0], e.a0);
                if (e.nrd > 1 && rd_log.size() > 1)
                    chk(rd_log[1] == e.a1, {e.tag, " R4 second read addr"}, rd_log[1], e.a1);
                rd_log.delete();
                held = 1'b0;
                ready_seen = 1'b0;
                busy = 1'b0;
            end
        end
    end

    task automatic run_tests();
        rst_n = 1'b0;
        base_wr_en = 1'b0; base_wr_frm = '0;
        req_valid = 1'b0; req_laddr = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #2;
        chk(req_ready == 1'b1, "R1 req_ready after reset", 32'(req_ready), 32'd1);
        chk(res_valid == 1'b0, "R1 res_valid after reset", 32'(res_valid), 32'd0);
        chk(mem_req_valid == 1'b0, "R1 mem_req_valid after reset", 32'(mem_req_valid), 32'd0);

        mem[32'h0001_0004] = 32'h0002_0001;
        mem[32'h0002_000C] = 32'h1234_5003;
        mem[32'h0001_00C0] = 32'h8040_0081;
        mem[32'h0001_0010] = 32'h0000_0080;
        mem[32'h0001_0FFC] = 32'h0003_0001;
        mem[32'h0003_0FFC] = 32'hABCD_E001;
        mem[32'h0005_0004] = 32'h0006_0001;
        mem[32'h0006_000C] = 32'h7777_7001;

        xlate(32'h0040_3ABC, 2'd1, 32'h0, 0, 32'h0, 32'h0, "R2 no base");
        set_base(20'h00010);
        xlate(32'h0040_3ABC, 2'd0, 32'h1234_5ABC, 2, 32'h0001_0004, 32'h0002_000C, "R4 4KB walk");
        xlate(32'h0C12_3456, 2'd0, 32'h8052_3456, 1, 32'h0001_00C0, 32'h0, "R5 4MB page");
        xlate(32'h0080_0010, 2'd2, 32'h0, 1, 32'h0001_0008, 32'h0, "R6 dir absent");
        xlate(32'h0100_0000, 2'd2, 32'h0, 1, 32'h0001_0010, 32'h0, "R6 dir absent size set");
        xlate(32'h0040_5000, 2'd3, 32'h0, 2, 32'h0001_0004, 32'h0002_0014, "R7 table absent");
        xlate(32'hFFFF_FFFF, 2'd0, 32'hABCD_EFFF, 2, 32'h0001_0FFC, 32'h0003_0FFC, "R3 top index");
        fork
            xlate(32'h0040_3ABC, 2'd0, 32'h1234_5ABC, 2, 32'h0001_0004, 32'h0002_000C,
                  "R10 old base in flight");
            begin
                repeat (4) @(negedge clk);
                set_base(20'h00050);
            end
        join
        xlate(32'h0040_3ABC, 2'd0, 32'h7777_7ABC, 2, 32'h0005_0004, 32'h0006_000C,
              "R10 new base next");
        repeat (3) @(negedge clk);
    endtask

    initial begin
        fork
            run_tests();
            begin
                repeat (20000) @(posedge clk);
                chk(1'b0, "watchdog expired", 32'(cyc), 32'd0);
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule